// File: doc/BRIEF.md
# Reconfigurable Proportional-Integral Loop Filter

This block is the digital loop filter of an all-digital phase-locked loop. Each time a qualified phase-error sample arrives on the reference clock, it forms a proportional term and an integral term, each scaled by a programmable arithmetic right shift. It then passes their sum through a cascade of first-order smoothing stages. The result is a registered, saturated frequency control word for the oscillator normaliser.

A single mode input selects type-I or type-II operation. In type-I the integrator is held at zero, which suits fast initial acquisition. In type-II the integrator joins the sum, which suits precise tracking once lock is near. Each smoothing stage has its own shift coefficient and its own bypass bit. With the integrator and the oscillator counted, the loop order can therefore be set anywhere from first to sixth. Software fills the coefficient fields; choosing their values is left to the system.

Top module: `pi_loop_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fcw_out` is 0 and `fcw_valid` is 0. All filter state starts at 0.
- R2: `fcw_valid` equals `err_valid` delayed by one clock. When `err_valid` was low, `fcw_out` keeps its previous value.
- R3: With `type2_en` low and every stage bypassed, a sample e gives `fcw_out` = e >>> `kp_shift` (arithmetic shift, signed two's complement) on the next cycle.
- R4: With `type2_en` high, each qualified sample adds e >>> `ki_shift` to the integrator. The pre-stage sum is (e >>> `kp_shift`) plus the updated integrator value.
- R5: On every clock where `type2_en` is low, the integrator is cleared. A cleared integrator adds nothing to the output.
- R6: The integrator saturates at +(2^(DATA_W-1))-1 and -2^(DATA_W-1) instead of wrapping. The proportional-plus-integral sum is clamped to the same range.
- R7: An enabled stage i keeps state y and, on each qualified sample with input x, sets y to y + ((x - y) >>> k_i). Its output is the new y. Here k_i is bits [4i+3:4i] of `iir_shift`.
- R8: A stage whose bit i in `iir_bypass` is 1 passes its input straight through and loads that input as its state. Stages are applied in order from index 0 to NSTAGE-1.
- R9: `fcw_out` is the last stage output clamped to the signed OUT_W range [-2^(OUT_W-1), 2^(OUT_W-1)-1].
- R10: All shift fields accept every value 0 to 15. A shift of 0 gives unit gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Qualifies `err_in` for this cycle |
| err_in | input | ERR_W | Signed phase-error sample |
| type2_en | input | 1 | 1 = integrator active (type-II), 0 = cleared (type-I) |
| kp_shift | input | 4 | Proportional right-shift amount |
| ki_shift | input | 4 | Integral right-shift amount |
| iir_shift | input | 4*NSTAGE | Per-stage shift, stage i in bits [4i+3:4i] |
| iir_bypass | input | NSTAGE | Per-stage bypass, 1 = pass through |
| fcw_valid | output | 1 | Marks a fresh `fcw_out` |
| fcw_out | output | OUT_W | Signed saturated frequency control word |

## Verification
The bench builds the filter with ERR_W=12, DATA_W=20, OUT_W=16 and four stages. With a 20-bit integrator, a full-scale error at unit integral gain reaches the positive clamp in about 256 samples. Recovery from that clamp under full-scale negative error then shows whether the value saturated or wrapped. With only 16 output bits, the output clamp is hit well before the integrator clamp. The gap between the two can therefore be observed at the ports. Shift values 0 and 15, mixed bypass patterns, gaps in the valid stream and type switches mid-stream are compared sample by sample against a behavioural model.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int SHAMT_W = 4;
    typedef logic [SHAMT_W-1:0] shamt_t;
endpackage

// File: rtl/lf_integrator.sv
module lf_integrator
    import lf_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              type2,
    input  logic [DATA_W-1:0] err,
    input  shamt_t            rho_sh,
    output logic [DATA_W-1:0] acc_q_o,
    output logic [DATA_W-1:0] acc_nxt_o
);
    localparam int SUM_W = DATA_W + 1;
    localparam logic signed [SUM_W-1:0] MAXV = {2'b00, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] MINV = {2'b11, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;
    logic signed [DATA_W-1:0] inc;
    logic signed [SUM_W-1:0]  sum;
    logic signed [DATA_W-1:0] clamped;

    always_comb begin
        st_d    = st_q;
        inc     = $signed(err) >>> rho_sh;
        sum     = $signed({st_q.acc[DATA_W-1], st_q.acc}) + $signed({inc[DATA_W-1], inc});
        if (sum > MAXV)
            clamped = MAXV[DATA_W-1:0];
        else if (sum < MINV)
            clamped = MINV[DATA_W-1:0];
        else
            clamped = sum[DATA_W-1:0];
        if (!type2)
            st_d.acc = '0;
        else if (upd)
            st_d.acc = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q_o   = st_q.acc;
    assign acc_nxt_o = st_d.acc;
endmodule

// File: rtl/lf_iir_stage.sv
module lf_iir_stage
    import lf_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              bypass,
    input  shamt_t            k_sh,
    input  logic [DATA_W-1:0] x_in,
    output logic [DATA_W-1:0] y_out
);
    localparam int DIF_W = DATA_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] y;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic signed [DIF_W-1:0]  diff;
    logic signed [DIF_W-1:0]  step;
    logic signed [DATA_W-1:0] y_new;

    always_comb begin
        st_d  = st_q;
        diff  = $signed({x_in[DATA_W-1], x_in}) - $signed({st_q.y[DATA_W-1], st_q.y});
        step  = diff >>> k_sh;
        y_new = DATA_W'($signed({st_q.y[DATA_W-1], st_q.y}) + step);
        y_out = bypass ? x_in : y_new;
        if (upd)
            st_d.y = y_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import lf_pkg::*;
#(
    parameter int ERR_W  = 12,
    parameter int DATA_W = 20,
    parameter int OUT_W  = 16,
    parameter int NSTAGE = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      err_valid,
    input  logic [ERR_W-1:0]          err_in,
    input  logic                      type2_en,
    input  logic [SHAMT_W-1:0]        kp_shift,
    input  logic [SHAMT_W-1:0]        ki_shift,
    input  logic [SHAMT_W*NSTAGE-1:0] iir_shift,
    input  logic [NSTAGE-1:0]         iir_bypass,
    output logic                      fcw_valid,
    output logic [OUT_W-1:0]          fcw_out
);
    localparam int SUM_W = DATA_W + 1;
    localparam logic signed [SUM_W-1:0]  PMAX = {2'b00, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0]  PMIN = {2'b11, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] OMAX = {{(DATA_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] OMIN = {{(DATA_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] fcw;
    } out_st_t;

    out_st_t st_d, st_q;

    logic signed [DATA_W-1:0] err_x;
    logic signed [DATA_W-1:0] prop;
    logic [DATA_W-1:0]        integ_state;
    logic [DATA_W-1:0]        integ_next;
    logic signed [SUM_W-1:0]  pi_wide;
    logic [DATA_W-1:0]        chain [NSTAGE+1];

    assign err_x = DATA_W'($signed(err_in));

    lf_integrator #(.DATA_W(DATA_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (err_valid),
        .type2     (type2_en),
        .err       (err_x),
        .rho_sh    (ki_shift),
        .acc_q_o   (integ_state),
        .acc_nxt_o (integ_next)
    );

    always_comb begin
        prop    = err_x >>> kp_shift;
        pi_wide = $signed({prop[DATA_W-1], prop});
        if (type2_en)
            pi_wide = pi_wide + $signed({integ_next[DATA_W-1], integ_next});
        if (pi_wide > PMAX)
            chain[0] = PMAX[DATA_W-1:0];
        else if (pi_wide < PMIN)
            chain[0] = PMIN[DATA_W-1:0];
        else
            chain[0] = pi_wide[DATA_W-1:0];
    end

    for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
        lf_iir_stage #(.DATA_W(DATA_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (err_valid),
            .bypass (iir_bypass[gi]),
            .k_sh   (iir_shift[gi*SHAMT_W +: SHAMT_W]),
            .x_in   (chain[gi]),
            .y_out  (chain[gi+1])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = err_valid;
        if (err_valid) begin
            if ($signed(chain[NSTAGE]) > OMAX)
                st_d.fcw = OMAX[OUT_W-1:0];
            else if ($signed(chain[NSTAGE]) < OMIN)
                st_d.fcw = OMIN[OUT_W-1:0];
            else
                st_d.fcw = chain[NSTAGE][OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fcw_valid = st_q.vld;
    assign fcw_out   = st_q.fcw;
endmodule

// File: rtl/pi_loop_filter_chk.sv
module pi_loop_filter_chk #(
    parameter int ERR_W  = 12,
    parameter int DATA_W = 20,
    parameter int OUT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_valid,
    input logic [ERR_W-1:0]  err_in,
    input logic              type2_en,
    input logic              fcw_valid,
    input logic [OUT_W-1:0]  fcw_out,
    input logic [DATA_W-1:0] integ_state
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> fcw_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> (!fcw_valid && $stable(fcw_out)));
    // R5
    integ_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !type2_en |=> (integ_state == '0));
    // R6
    integ_no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (type2_en && err_valid && !err_in[ERR_W-1])
        |=> ($signed(integ_state) >= $signed($past(integ_state))));
    // R6
    integ_no_wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (type2_en && err_valid && err_in[ERR_W-1])
        |=> ($signed(integ_state) <= $signed($past(integ_state))));
endmodule

bind pi_loop_filter pi_loop_filter_chk #(
    .ERR_W(ERR_W), .DATA_W(DATA_W), .OUT_W(OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_valid   (err_valid),
    .err_in      (err_in),
    .type2_en    (type2_en),
    .fcw_valid   (fcw_valid),
    .fcw_out     (fcw_out),
    .integ_state (integ_state)
);

// File: tb/pi_loop_filter_tb.sv
module pi_loop_filter_tb;
    localparam int ERR_W  = 12;
    localparam int DATA_W = 20;
    localparam int OUT_W  = 16;
    localparam int NSTAGE = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                err_valid = 1'b0;
    logic [ERR_W-1:0]    err_in = '0;
    logic                type2_en = 1'b0;
    logic [3:0]          kp_shift = '0;
    logic [3:0]          ki_shift = '0;
    logic [4*NSTAGE-1:0] iir_shift = '0;
    logic [NSTAGE-1:0]   iir_bypass = '1;
    logic                fcw_valid;
    logic [OUT_W-1:0]    fcw_out;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    comparing = 0;
    bit    finished = 0;
    string tag = "R1";

    longint m_acc, m_fcw;
    longint m_y [NSTAGE];
    bit     m_vld;

    always #2 clk = ~clk;

    pi_loop_filter #(.ERR_W(ERR_W), .DATA_W(DATA_W), .OUT_W(OUT_W), .NSTAGE(NSTAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
        .type2_en(type2_en), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .iir_shift(iir_shift), .iir_bypass(iir_bypass),
        .fcw_valid(fcw_valid), .fcw_out(fcw_out)
    );

    function automatic longint clampw(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        longint lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Behavioural reference of R1..R10
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_fcw = 0; m_vld = 0;
            for (int i = 0; i < NSTAGE; i++) m_y[i] = 0;
        end else begin
            longint e, x;
            if (!type2_en) m_acc = 0;
            if (err_valid) begin
                e = longint'($signed(err_in));
                if (type2_en) m_acc = clampw(m_acc + (e >>> ki_shift), DATA_W);
                x = clampw((e >>> kp_shift) + (type2_en ? m_acc : 0), DATA_W);
                for (int i = 0; i < NSTAGE; i++) begin
                    if (iir_bypass[i]) m_y[i] = x;
                    else m_y[i] = m_y[i] + ((x - m_y[i]) >>> iir_shift[4*i +: 4]);
                    x = m_y[i];
                end
                m_fcw = clampw(x, OUT_W);
            end
            m_vld = err_valid;
        end
    end

    always @(negedge clk) begin
        if (comparing && !finished) begin
            longint got;
            got = longint'($signed(fcw_out));
            n_checks++;
            if (got != m_fcw || fcw_valid != m_vld) begin
                n_fail++;
                $display("FAIL %s: fcw_out=%0d valid=%0b expected %0d valid=%0b",
                         tag, got, fcw_valid, m_fcw, m_vld);
            end
        end
    end

    task automatic cyc(input int e, input bit v);
        err_in    = ERR_W'(e);
        err_valid = v;
        @(negedge clk);
    endtask

    task automatic expect_out(input string t, input longint exp);
        longint got;
        got = longint'($signed(fcw_out));
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: fcw_out=%0d expected %0d", t, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        n_checks++;
        if (fcw_out != '0 || fcw_valid != 1'b0) begin
            n_fail++;
            $display("FAIL R1: fcw_out=%0d valid=%0b expected 0 valid=0", fcw_out, fcw_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        comparing = 1;

        // R3: type-I proportional only, all stages bypassed
        tag = "R3";
        kp_shift = 4'd0;
        cyc(100, 1); expect_out("R3", 100);
        cyc(-100, 1); expect_out("R3", -100);
        kp_shift = 4'd3;
        cyc(-9, 1); expect_out("R3", -2);
        cyc(2047, 1); expect_out("R3", 255);

        // R2: gaps in the valid stream hold the output
        tag = "R2";
        cyc(-500, 0); expect_out("R2", 255);
        cyc(7, 0);
        cyc(64, 1); expect_out("R2", 8);
        cyc(0, 0);

        // R10: extreme shift amounts
        tag = "R10";
        kp_shift = 4'd15;
        cyc(2047, 1); expect_out("R10", 0);
        cyc(-2048, 1); expect_out("R10", -1);

        // R4: integrator accumulates
        tag = "R4";
        kp_shift = 4'd6; ki_shift = 4'd2; type2_en = 1'b1;
        for (int i = 0; i < 20; i++) cyc(400, (i % 3) != 2);
        for (int i = 0; i < 10; i++) cyc(-123, 1);

        // R5: dropping type-II clears the integrator
        tag = "R5";
        type2_en = 1'b0;
        cyc(0, 0);
        cyc(0, 1); expect_out("R5", 0);
        type2_en = 1'b1;
        cyc(4, 1); expect_out("R5", 1);

        // R6/R9: integrator and output saturation, then recovery
        tag = "R9";
        kp_shift = 4'd0; ki_shift = 4'd0;
        for (int i = 0; i < 320; i++) cyc(2047, 1);
        expect_out("R9", 32767);
        tag = "R6";
        for (int i = 0; i < 250; i++) cyc(-2048, 1);
        for (int i = 0; i < 600; i++) cyc(-2048, 1);
        expect_out("R9", -32768);
        type2_en = 1'b0;
        cyc(0, 1);

        // R7: smoothing stages enabled
        tag = "R7";
        kp_shift = 4'd0;
        iir_bypass = 4'b0000;
        iir_shift  = {4'd5, 4'd5, 4'd5, 4'd5};
        for (int i = 0; i < 60; i++) cyc(1000, 1);
        iir_shift  = {4'd0, 4'd15, 4'd1, 4'd2};
        for (int i = 0; i < 30; i++) cyc(-700, (i % 4) != 0);

        // R8: mixed bypass patterns, type-II order changes
        tag = "R8";
        type2_en = 1'b1; ki_shift = 4'd10; kp_shift = 4'd7;
        iir_bypass = 4'b1010;
        iir_shift  = {4'd3, 4'd4, 4'd2, 4'd1};
        for (int i = 0; i < 40; i++) cyc(((i % 2) != 0) ? 1500 : -300, 1);
        iir_bypass = 4'b0110;
        for (int i = 0; i < 40; i++) cyc(900 - 40 * i, 1);
        iir_bypass = 4'b1111;
        cyc(256, 1);

        comparing = 0;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule